// File: doc/BRIEF.md
# Three-Byte SPI Host Sequencer with Ready Gating

This block is the host end of a link to a slave that exchanges fixed frames of three bytes. A frame starts on one of two triggers: a single-cycle software request, which is held until it can be served, or a high level on a change-notification input from the slave. A frame only starts while the slave's ready line is high. The sequencer then pulls chip-select low and waits a setup interval. Next it runs an idle-high serial clock with fixed half-periods and exchanges 24 bits, most significant first. It releases chip-select half a period after the final rising edge.

All timing comes from counts of the system clock. One parameter sets the setup interval. A second sets the half-period, which fixes both the minimum low and high times and the maximum clock rate. A third sets the budget for the whole frame. A frame is aborted if the ready line drops before the last rising edge or if the budget runs out. An abort raises an error pulse and returns chip-select and the clock to idle. A normal frame ends with a one-cycle done pulse, together with the received word. The first byte received is placed in the top eight bits.

Top module: `spi_frame_host`

## Requirements
- R1: After reset, cs_n and sclk are high and done and err are low. Whenever cs_n is high, sclk is high.
- R2: A frame starts only while rdy_in is high. A one-cycle start_req is remembered while rdy_in is low and is served once rdy_in rises. A high change_in also starts a frame.
- R3: The first sclk falling edge comes exactly SETUP_CYC clock cycles after cs_n falls.
- R4: Every sclk low phase and every sclk high phase inside a frame lasts exactly HALF_CYC clock cycles. A frame has 24 rising edges.
- R5: mosi changes only at sclk falling edges. It carries tx_word starting with bit 23 and ending with bit 0.
- R6: miso is sampled at sclk rising edges. The first bit received lands in rx_word bit 23, so byte 1 occupies rx_word[23:16].
- R7: cs_n stays low for the whole frame. It rises exactly HALF_CYC cycles after the last rising edge, in the same cycle that done is high.
- R8: done is high for exactly one cycle, and rx_word holds the completed received word in that cycle.
- R9: If rdy_in is low at any clock edge from the launch until the last rising edge, the frame aborts at that edge. err pulses for one cycle, cs_n and sclk go high in the same cycle, and done does not pulse.
- R10: A frame still running FRAME_CYC cycles after cs_n fell aborts in that cycle with the same err behaviour as R9.
- R11: rdy_in going low after the last rising edge, during the hold before cs_n rises, causes no abort: done pulses with the correct word and err stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Single-cycle software request for a frame |
| change_in | input | 1 | Slave change notification, level-sensitive request |
| rdy_in | input | 1 | Slave ready line; clocking allowed only while high |
| tx_word | input | 24 | Word to send, captured at frame launch |
| miso | input | 1 | Serial data from the slave |
| cs_n | output | 1 | Chip-select, active low |
| sclk | output | 1 | Serial clock, idle high |
| mosi | output | 1 | Serial data to the slave |
| rx_word | output | 24 | Received word, valid with done |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle abort pulse |

## Verification
The tightest overlap is between completing a frame and the ready line dropping. A slave is expected to lower its ready line right after it has shifted the third byte, which can happen in the same cycles as the hold phase that ends with done. The bench models this: its slave lowers rdy_in as soon as the 24th rising edge has been seen and keeps it low through the hold phase. The bench requires a done pulse carrying the right word with no err. The same line dropped during a low phase must instead produce err in the very next cycle, with cs_n and sclk back high and no done.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_HOLD
  } seq_state_t;
endpackage

// File: rtl/spi_phase_timer.sv
// Counts cycles in the current phase; hit marks the final cycle of the phase.
module spi_phase_timer #(
  parameter int TW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [TW-1:0] lim,
  output logic          hit
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= cnt + TW'(1);
  end

  assign hit = (cnt == lim);
endmodule

// File: rtl/spi_budget_timer.sv
// Counts cycles since the frame launched; over marks the last allowed cycle.
module spi_budget_timer #(
  parameter int FRAME_CYC = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic over
);
  localparam int BW = $clog2(FRAME_CYC + 1);
  logic [BW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (!over)   cnt <= cnt + BW'(1);
  end

  assign over = (cnt == BW'(FRAME_CYC - 1));
endmodule

// File: rtl/spi_shifter.sv
// One register serves both directions: the top bit goes out, the incoming bit enters at the bottom.
module spi_shifter #(
  parameter int NBITS = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [NBITS-1:0] load_val,
  input  logic             shift,
  input  logic             din,
  output logic             msb,
  output logic [NBITS-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst)        word <= '0;
    else if (load)  word <= load_val;
    else if (shift) word <= {word[NBITS-2:0], din};
  end

  assign msb = word[NBITS-1];
endmodule

// File: rtl/spi_frame_host.sv
module spi_frame_host
  import spi_host_pkg::*;
#(
  parameter int NBYTES    = 3,
  parameter int SETUP_CYC = 1120,
  parameter int HALF_CYC  = 358,
  parameter int FRAME_CYC = 500000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_req,
  input  logic                  change_in,
  input  logic                  rdy_in,
  input  logic [NBYTES*8-1:0]   tx_word,
  input  logic                  miso,
  output logic                  cs_n,
  output logic                  sclk,
  output logic                  mosi,
  output logic [NBYTES*8-1:0]   rx_word,
  output logic                  done,
  output logic                  err
);
  localparam int NBITS = NBYTES * 8;
  localparam int BITW  = $clog2(NBITS + 1);
  localparam int LMAX  = (SETUP_CYC > HALF_CYC) ? SETUP_CYC : HALF_CYC;
  localparam int TW    = $clog2(LMAX + 1);
  localparam logic [TW-1:0] SETUP_LIM = TW'(SETUP_CYC - 1);
  localparam logic [TW-1:0] HALF_LIM  = TW'(HALF_CYC - 1);

  seq_state_t        state;
  logic              pend;
  logic [BITW-1:0]   bit_cnt;
  logic              hit, over, sh_msb;
  logic [NBITS-1:0]  sh_word;
  logic              busy, live, launch, abort, step, last_bit, shift_en;
  logic [TW-1:0]     lim;

  assign busy     = (state != ST_IDLE);
  assign live     = (state == ST_SETUP) || (state == ST_LOW) || (state == ST_HIGH);
  assign launch   = !busy && (pend || change_in) && rdy_in;
  assign abort    = (live && !rdy_in) || (busy && over);
  assign step     = busy && hit;
  assign last_bit = (bit_cnt == BITW'(NBITS - 1));
  assign shift_en = (state == ST_LOW) && step && !abort;
  assign lim      = (state == ST_SETUP) ? SETUP_LIM : HALF_LIM;

  spi_phase_timer #(.TW(TW)) u_phase (
    .clk (clk),
    .rst (rst),
    .clr (!busy || step),
    .lim (lim),
    .hit (hit)
  );

  spi_budget_timer #(.FRAME_CYC(FRAME_CYC)) u_budget (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .over (over)
  );

  spi_shifter #(.NBITS(NBITS)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (launch),
    .load_val (tx_word),
    .shift    (shift_en),
    .din      (miso),
    .msb      (sh_msb),
    .word     (sh_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      pend    <= 1'b0;
      bit_cnt <= '0;
      cs_n    <= 1'b1;
      sclk    <= 1'b1;
      mosi    <= 1'b0;
      rx_word <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (start_req) pend <= 1'b1;
      if (abort) begin
        state <= ST_IDLE;
        cs_n  <= 1'b1;
        sclk  <= 1'b1;
        err   <= 1'b1;
      end else begin
        unique case (state)
          ST_IDLE: if (launch) begin
            state   <= ST_SETUP;
            cs_n    <= 1'b0;
            pend    <= 1'b0;
            bit_cnt <= '0;
          end
          ST_SETUP: if (hit) begin
            state <= ST_LOW;
            sclk  <= 1'b0;
            mosi  <= sh_msb;
          end
          ST_LOW: if (hit) begin
            sclk    <= 1'b1;
            bit_cnt <= bit_cnt + BITW'(1);
            state   <= last_bit ? ST_HOLD : ST_HIGH;
          end
          ST_HIGH: if (hit) begin
            state <= ST_LOW;
            sclk  <= 1'b0;
            mosi  <= sh_msb;
          end
          ST_HOLD: if (hit) begin
            state   <= ST_IDLE;
            cs_n    <= 1'b1;
            done    <= 1'b1;
            rx_word <= sh_word;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_frame_host_chk.sv
module spi_frame_host_chk #(
  parameter int HALF_CYC = 358
) (
  input logic clk,
  input logic rst,
  input logic rdy_in,
  input logic cs_n,
  input logic sclk,
  input logic mosi,
  input logic done,
  input logic err
);
  int   lo_run, hi_run;
  logic seen_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_run    <= 0;
      hi_run    <= 0;
      seen_fall <= 1'b0;
    end else begin
      lo_run    <= sclk ? 0 : lo_run + 1;
      hi_run    <= sclk ? hi_run + 1 : 0;
      seen_fall <= cs_n ? 1'b0 : (seen_fall | !sclk);
    end
  end

  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst) cs_n |-> sclk); // R1
  AST_LAUNCH_NEEDS_RDY: assert property (@(posedge clk) disable iff (rst) $fell(cs_n) |-> $past(rdy_in)); // R2
  AST_LOW_WIDTH: assert property (@(posedge clk) disable iff (rst) ($rose(sclk) && !err) |-> (lo_run >= HALF_CYC)); // R4
  AST_HIGH_WIDTH: assert property (@(posedge clk) disable iff (rst) ($fell(sclk) && seen_fall) |-> (hi_run >= HALF_CYC)); // R4
  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (rst) (sclk && $past(sclk) && !cs_n) |-> $stable(mosi)); // R5
  AST_FALL_IN_FRAME: assert property (@(posedge clk) disable iff (rst) $fell(sclk) |-> !cs_n); // R7
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (rst) done |-> cs_n); // R7
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R8
  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (rst) err |-> (cs_n && sclk && !done)); // R9
endmodule

bind spi_frame_host spi_frame_host_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .rdy_in (rdy_in),
  .cs_n   (cs_n),
  .sclk   (sclk),
  .mosi   (mosi),
  .done   (done),
  .err    (err)
);

// File: tb/tb_spi_frame_host.sv
`timescale 1ns/1ps
module tb_spi_frame_host;
  localparam int S  = 20;
  localparam int H  = 8;
  localparam int F  = 600;
  localparam int FS = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_req = 1'b0, change_in = 1'b0, rdy = 1'b1;
  logic [23:0] tx_word = '0;
  logic miso = 1'b0;
  logic cs_n, sclk, mosi, done, err;
  logic [23:0] rx_word;
  logic s_start = 1'b0;
  logic s_cs_n, s_sclk, s_mosi, s_done, s_err;
  logic [23:0] s_rx;

  always #10 clk = ~clk;

  spi_frame_host #(.NBYTES(3), .SETUP_CYC(S), .HALF_CYC(H), .FRAME_CYC(F)) dut (
    .clk(clk), .rst(rst), .start_req(start_req), .change_in(change_in), .rdy_in(rdy),
    .tx_word(tx_word), .miso(miso), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .rx_word(rx_word), .done(done), .err(err));

  spi_frame_host #(.NBYTES(3), .SETUP_CYC(S), .HALF_CYC(H), .FRAME_CYC(FS)) dut_short (
    .clk(clk), .rst(rst), .start_req(s_start), .change_in(1'b0), .rdy_in(1'b1),
    .tx_word(24'h5A5A5A), .miso(1'b0), .cs_n(s_cs_n), .sclk(s_sclk), .mosi(s_mosi),
    .rx_word(s_rx), .done(s_done), .err(s_err));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Slave model: shifts out on falling edges, captures on rising edges.
  logic [23:0] sl_resp = '0, sl_out = '0, sl_in = '0;
  int rises = 0;
  always @(negedge cs_n) begin sl_out = sl_resp; rises = 0; end
  always @(negedge sclk) if (!cs_n) begin miso = sl_out[23]; sl_out = sl_out << 1; end
  always @(posedge sclk) if (!cs_n) begin sl_in = {sl_in[22:0], mosi}; rises++; end

  // Measurement and scoreboard monitor, sampling mid-cycle.
  logic [23:0] exp_rx_q[$];
  logic [23:0] exp_tx_q[$];
  int cyc = 0, cs_t = 0, edge_t = 0, last_rise = 0;
  int setup_meas = 0, hold_meas = 0, lo_min = 0, lo_max = 0, hi_min = 0, hi_max = 0;
  int done_seen = 0, err_seen = 0;
  bit first_pend = 0, err_ok = 0, p_cs = 1, p_sclk = 1, p_done = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (p_cs && !cs_n) begin
        cs_t = cyc; first_pend = 1;
        lo_min = 99999; lo_max = 0; hi_min = 99999; hi_max = 0;
      end else if (p_sclk != sclk && !cs_n) begin
        if (!sclk) begin
          if (first_pend) begin setup_meas = cyc - cs_t; first_pend = 0; end
          else begin
            if (cyc - edge_t < hi_min) hi_min = cyc - edge_t;
            if (cyc - edge_t > hi_max) hi_max = cyc - edge_t;
          end
        end else begin
          if (cyc - edge_t < lo_min) lo_min = cyc - edge_t;
          if (cyc - edge_t > lo_max) lo_max = cyc - edge_t;
          last_rise = cyc;
        end
        edge_t = cyc;
      end
      if (!p_cs == 1'b1 && cs_n === 1'b1) hold_meas = cyc - last_rise;
      if (p_done) chk(done == 1'b0, "R8", "done width", done, 0);
      if (done) begin
        done_seen++;
        chk(err == 1'b0, "R9", "err with done", err, 0);
        chk(cs_n == 1'b1, "R7", "cs_n at done", cs_n, 1);
        if (exp_rx_q.size() == 0) chk(1'b0, "R8", "unexpected done", 1, 0);
        else begin
          logic [23:0] er, et;
          er = exp_rx_q.pop_front();
          et = exp_tx_q.pop_front();
          chk(rx_word == er, "R6", "rx_word", rx_word, er);
          chk(sl_in == et, "R5", "mosi word at slave", sl_in, et);
        end
      end
      if (err) begin
        err_seen++;
        if (!err_ok) chk(1'b0, "R9", "unexpected err", 1, 0);
      end
    end
    p_cs = (cs_n !== 1'b0); p_sclk = (sclk !== 1'b0); p_done = (done === 1'b1);
  end

  task automatic frame_checks(input string tag);
    chk(setup_meas == S, "R3", {tag, " setup cycles"}, setup_meas, S);
    chk(lo_min == H && lo_max == H, "R4", {tag, " low phase"}, lo_max, H);
    chk(hi_min == H && hi_max == H, "R4", {tag, " high phase"}, hi_max, H);
    chk(rises == 24, "R4", {tag, " rising edges"}, rises, 24);
    chk(hold_meas == H, "R7", {tag, " hold after last rise"}, hold_meas, H);
  endtask

  task automatic run_frame(input logic [23:0] tx, input logic [23:0] resp,
                           input bit use_change, input bit drop_in_hold);
    int n0;
    @(negedge clk);
    tx_word = tx; sl_resp = resp;
    exp_rx_q.push_back(resp); exp_tx_q.push_back(tx);
    n0 = done_seen;
    if (use_change) change_in = 1'b1; else start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    while (cs_n) @(negedge clk);
    change_in = 1'b0;
    if (drop_in_hold) begin
      while (rises < 24) @(negedge clk);
      rdy = 1'b0;
    end
    while (done_seen == n0) @(negedge clk);
    rdy = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "ALL", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int n0, e0, t0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(cs_n == 1'b1, "R1", "cs_n in reset", cs_n, 1);
    chk(sclk == 1'b1, "R1", "sclk in reset", sclk, 1);
    chk(done == 1'b0 && err == 1'b0, "R1", "done/err in reset", {done, err}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b1, "R1", "idle after reset", {cs_n, sclk}, 3);

    // R2/R5/R6: software-requested frame
    run_frame(24'hA53C0F, 24'h817EC3, 1'b0, 1'b0);
    frame_checks("start_req frame");

    // R2: change notification starts a frame
    run_frame(24'h00FF00, 24'h123456, 1'b1, 1'b0);
    frame_checks("change frame");

    // R11: ready drops during hold, completion must still occur
    e0 = err_seen;
    run_frame(24'hFFFFFF, 24'h000001, 1'b0, 1'b1);
    chk(err_seen == e0, "R11", "no err on hold-phase drop", err_seen - e0, 0);

    // R2: request held off while rdy_in low, served later
    @(negedge clk);
    rdy = 1'b0; tx_word = 24'h3C3C3C; sl_resp = 24'hC0FFEE;
    start_req = 1'b1; @(negedge clk); start_req = 1'b0;
    repeat (100) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b1, "R2", "no frame while rdy low", {cs_n, sclk}, 3);
    exp_rx_q.push_back(24'hC0FFEE); exp_tx_q.push_back(24'h3C3C3C);
    n0 = done_seen;
    rdy = 1'b1;
    while (done_seen == n0) @(negedge clk);
    chk(1'b1, "R2", "pending request served", 1, 1);

    // R9: ready drops in a low phase mid-frame
    @(negedge clk);
    tx_word = 24'h111111; sl_resp = 24'h222222;
    n0 = done_seen; e0 = err_seen;
    start_req = 1'b1; @(negedge clk); start_req = 1'b0;
    while (rises < 5 || sclk) @(negedge clk);
    err_ok = 1; rdy = 1'b0;
    @(negedge clk);
    chk(err == 1'b1, "R9", "err after rdy drop", err, 1);
    chk(cs_n == 1'b1 && sclk == 1'b1, "R9", "lines idle at abort", {cs_n, sclk}, 3);
    @(negedge clk);
    chk(err == 1'b0, "R9", "err width", err, 0);
    rdy = 1'b1;
    repeat (50) @(negedge clk);
    chk(done_seen == n0, "R9", "no done after abort", done_seen - n0, 0);
    chk(cs_n == 1'b1, "R9", "stays idle after abort", cs_n, 1);
    err_ok = 0;

    // R10: frame budget expiry on the short-budget instance
    s_start = 1'b1; @(negedge clk); s_start = 1'b0;
    while (s_cs_n) @(negedge clk);
    t0 = cyc;
    while (!s_err && cyc - t0 < 1000) @(negedge clk);
    chk(cyc - t0 == FS, "R10", "cycles to timeout", cyc - t0, FS);
    chk(s_cs_n == 1'b1 && s_sclk == 1'b1, "R10", "lines idle at timeout", {s_cs_n, s_sclk}, 3);
    chk(s_done == 1'b0, "R10", "no done on timeout", s_done, 0);

    repeat (5) @(negedge clk);
    chk(exp_rx_q.size() == 0, "R8", "all frames completed", exp_rx_q.size(), 0);
    finish_run();
  end
endmodule